// File: doc/BRIEF.md
# Multi-Scale Packed Extremum Detector

This block scans a raster stream of blob-strength responses and marks the spatial and scale peaks in it. Each input pixel word carries a stack of response lanes: one lane for each detectable scale, one lane below the lowest scale and one lane above the highest. The two outer lanes only serve as neighbours, so every detectable scale has a full three-scale neighbourhood. A value counts as a peak only when it is strictly larger than all 26 values around it in a 3x3 window that spans its own scale and the two scales next to it. All scales are tested in parallel against the same window.

The results are reduced over 2x2 pixel cells. Each cell yields one 32-bit word, so the result plane is half the input size in both directions. A word gives the position of the reporting pixel inside its cell, a mask with one bit per scale, and an octave tag. Two line buffers hold the previous rows. A column buffer holds the upper half of each cell until the lower row has been scanned. Pixels enter through a valid/ready port and results leave through one too. When a result word is not taken, the input is stalled: `in_ready` is low whenever `out_valid` is high and `out_ready` is low. No word is ever dropped or duplicated. The frame size, octave tag and strength floor are plain configuration pins. They are held steady while a frame is in flight.

Top module: `scale_peak_packer`

## Requirements
- R1: After reset `out_valid` is low, `in_ready` is high, and the next accepted pixel is taken as column 0, row 0 of a frame.
- R2: A frame of even width W and even height H (each 2 up to the maximum) produces exactly (W/2)*(H/2) result words, in raster order of cells.
- R3: Result word layout: bits [7:0] hold the column offset (0 or 1), bits [15:8] the row offset (0 or 1), bits [23:16] the scale mask with bit s for scale s and zeros above the scale count, and bits [31:24] a copy of `cfg_octave`.
- R4: Scale s is detected at a pixel only when its value (lane s+1) is strictly greater than each of the 26 other values in lanes s, s+1 and s+2 over the 3x3 window centred on that pixel. Equal values suppress detection.
- R5: Lane 0 (bits [DW-1:0]) and lane NS+1 (the top DW bits) act only as neighbours for scales 0 and NS-1. They never produce a mask bit themselves, and a large value there suppresses the adjacent scale.
- R6: Pixels in the first or last row or column of the frame never report a detection.
- R7: A detection also needs the centre value to be strictly greater than `cfg_floor`.
- R8: Inside a cell the pixels are examined in the order top-left, top-right, bottom-left, bottom-right. The first pixel with any detection supplies both offsets and the whole mask. A cell with no detection gives zero offsets and a zero mask.
- R9: A word on the output is held stable while `out_ready` is low, and `in_ready` is low in that state.
- R10: Frames follow each other without gaps or reset. The pixel after the last pixel of a frame is column 0, row 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | $clog2(MAXW+1) | Frame width in pixels, even |
| cfg_height | input | $clog2(MAXH+1) | Frame height in pixels, even |
| cfg_octave | input | 8 | Octave tag copied into each word |
| cfg_floor | input | DW | Minimum strength a peak must exceed |
| in_valid | input | 1 | Pixel word present |
| in_ready | output | 1 | Pixel word accepted when high with in_valid |
| in_data | input | (NS+2)*DW | Lanes 0..NS+1, lane 0 in the low bits |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result word |
| out_data | output | 32 | Packed cell result |

## Verification
The cell merge finishes a cell on the same accepted pixel that can also meet a full output register. In that cycle the cell's word must wait, and the input must stop so that no later cell overwrites it. The bench provokes this by dropping `out_ready` on a pseudo-random pattern while it feeds pixels in bursts. It compares every word, in order, with a model computed from the peak definition, and checks that a stalled word is unchanged in the next cycle. Crafted frames place peaks on the border, in the outer lanes and on two pixels of one cell, so that the border rule, the neighbour-only lanes and the cell priority each decide a word.

// File: rtl/spp_pkg.sv
package spp_pkg;

  localparam int SPP_MASK_BITS = 8;
  localparam int SPP_WORD_BITS = 32;

  function automatic logic [SPP_WORD_BITS-1:0] spp_pack(
    input logic [7:0]               octave,
    input logic [SPP_MASK_BITS-1:0] mask,
    input logic                     row_off,
    input logic                     col_off
  );
    return {octave, mask, 7'd0, row_off, 7'd0, col_off};
  endfunction

endpackage

// File: rtl/spp_line_window.sv
module spp_line_window #(
  parameter int DW   = 8,
  parameter int NL   = 6,
  parameter int MAXW = 64,
  localparam int PW  = NL * DW,
  localparam int AW  = $clog2(MAXW)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [AW-1:0]               col,
  input  logic [PW-1:0]               pix,
  output logic [2:0][2:0][PW-1:0]     win
);

  logic [PW-1:0] above1 [0:MAXW-1];
  logic [PW-1:0] above2 [0:MAXW-1];
  logic [2:0][PW-1:0] left2;
  logic [2:0][PW-1:0] left1;
  logic [2:0][PW-1:0] fresh;

  always_comb begin
    fresh[0] = above2[col];
    fresh[1] = above1[col];
    fresh[2] = pix;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      above1[col] <= pix;
      above2[col] <= above1[col];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left2 <= '0;
      left1 <= '0;
    end else if (push) begin
      left2 <= left1;
      left1 <= fresh;
    end
  end

  genvar r;
  generate
    for (r = 0; r < 3; r++) begin : g_row
      assign win[r][0] = left2[r];
      assign win[r][1] = left1[r];
      assign win[r][2] = fresh[r];
    end
  endgenerate

endmodule

// File: rtl/spp_peak_test.sv
module spp_peak_test #(
  parameter int DW  = 8,
  parameter int NS  = 4,
  localparam int NL = NS + 2,
  localparam int PW = NL * DW
) (
  input  logic [2:0][2:0][PW-1:0] win,
  input  logic [DW-1:0]           floor_lvl,
  input  logic                    interior,
  output logic [NS-1:0]           hits
);

  genvar s;
  generate
    for (s = 0; s < NS; s++) begin : g_scale
      logic [DW-1:0] centre;
      logic          wins;
      always_comb begin
        centre = win[1][1][(s+1)*DW +: DW];
        wins   = interior && (centre > floor_lvl);
        for (int r = 0; r < 3; r++) begin
          for (int c = 0; c < 3; c++) begin
            for (int d = 0; d < 3; d++) begin
              if (!(r == 1 && c == 1 && d == 1)) begin
                if (!(centre > win[r][c][(s+d)*DW +: DW])) wins = 1'b0;
              end
            end
          end
        end
        hits[s] = wins;
      end
    end
  endgenerate

endmodule

// File: rtl/spp_cell_merge.sv
module spp_cell_merge #(
  parameter int NS   = 4,
  parameter int MAXW = 64,
  localparam int NC  = MAXW / 2,
  localparam int CA  = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          col_odd,
  input  logic          col_last,
  input  logic          row_odd,
  input  logic          row_last,
  input  logic [CA-1:0] cell_col,
  input  logic [NS-1:0] hits,
  output logic          emit,
  output logic          col_off,
  output logic          row_off,
  output logic [NS-1:0] mask
);

  logic [NS-1:0] left_hits;
  logic [NS-1:0] upper_mask [0:NC-1];
  logic          upper_col  [0:NC-1];

  logic          pair_done;
  logic [NS-1:0] pair_mask;
  logic          pair_col;
  logic [NS-1:0] top_mask;
  logic          top_col;

  always_comb begin
    pair_done = step && (col_odd || col_last);
    if (col_odd && (left_hits != '0)) begin
      pair_mask = left_hits;
      pair_col  = 1'b0;
    end else begin
      pair_mask = hits;
      pair_col  = col_odd && (hits != '0);
    end
  end

  always_comb begin
    emit     = pair_done && (row_odd || row_last);
    top_mask = row_odd ? upper_mask[cell_col] : pair_mask;
    top_col  = row_odd ? upper_col[cell_col]  : pair_col;
    if (top_mask != '0) begin
      mask    = top_mask;
      col_off = top_col;
      row_off = 1'b0;
    end else if (row_odd && (pair_mask != '0)) begin
      mask    = pair_mask;
      col_off = pair_col;
      row_off = 1'b1;
    end else begin
      mask    = '0;
      col_off = 1'b0;
      row_off = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hits <= '0;
    end else if (step && !col_odd) begin
      left_hits <= hits;
    end
  end

  always_ff @(posedge clk) begin
    if (pair_done && !row_odd && !row_last) begin
      upper_mask[cell_col] <= pair_mask;
      upper_col[cell_col]  <= pair_col;
    end
  end

endmodule

// File: rtl/scale_peak_packer.sv
module scale_peak_packer
  import spp_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NS   = 4,
  parameter int MAXW = 64,
  parameter int MAXH = 64,
  localparam int NL  = NS + 2,
  localparam int PW  = NL * DW,
  localparam int WW  = $clog2(MAXW + 1),
  localparam int HW  = $clog2(MAXH + 1),
  localparam int AW  = $clog2(MAXW),
  localparam int NC  = MAXW / 2,
  localparam int CA  = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] cfg_width,
  input  logic [HW-1:0] cfg_height,
  input  logic [7:0]    cfg_octave,
  input  logic [DW-1:0] cfg_floor,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_data
);

  logic [WW-1:0] col_q;
  logic [HW-1:0] row_q;
  logic          take;
  logic          at_col_end;
  logic          at_row_end;
  logic          interior;
  logic          step;
  logic [CA-1:0] cell_col;

  logic [2:0][2:0][PW-1:0] win;
  logic [NS-1:0]           hits;
  logic                    emit;
  logic                    c_off;
  logic                    r_off;
  logic [NS-1:0]           cell_mask;
  logic [SPP_MASK_BITS-1:0] mask_wide;

  assign in_ready   = !out_valid || out_ready;
  assign take       = in_valid && in_ready;
  assign at_col_end = (col_q == cfg_width - WW'(1));
  assign at_row_end = (row_q == cfg_height - HW'(1));
  assign interior   = (col_q >= WW'(2)) && (row_q >= HW'(2));
  assign step       = take && (col_q != '0) && (row_q != '0);
  assign cell_col   = col_q[CA:1] - {{(CA-1){1'b0}}, ~col_q[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (take) begin
      if (at_col_end) begin
        col_q <= '0;
        row_q <= at_row_end ? '0 : row_q + HW'(1);
      end else begin
        col_q <= col_q + WW'(1);
      end
    end
  end

  spp_line_window #(.DW(DW), .NL(NL), .MAXW(MAXW)) window_i (
    .clk  (clk),
    .rst_n(rst_n),
    .push (take),
    .col  (col_q[AW-1:0]),
    .pix  (in_data),
    .win  (win)
  );

  spp_peak_test #(.DW(DW), .NS(NS)) peak_i (
    .win      (win),
    .floor_lvl(cfg_floor),
    .interior (interior),
    .hits     (hits)
  );

  spp_cell_merge #(.NS(NS), .MAXW(MAXW)) merge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .col_odd (!col_q[0]),
    .col_last(at_col_end),
    .row_odd (!row_q[0]),
    .row_last(at_row_end),
    .cell_col(cell_col),
    .hits    (hits),
    .emit    (emit),
    .col_off (c_off),
    .row_off (r_off),
    .mask    (cell_mask)
  );

  always_comb begin
    mask_wide = '0;
    mask_wide[NS-1:0] = cell_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take && emit) begin
      out_valid <= 1'b1;
      out_data  <= spp_pack(cfg_octave, mask_wide, r_off, c_off);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/spp_peak_checker.sv
module spp_peak_checker #(
  parameter int NS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_hold_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_stall_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[7:1] == 7'd0 && out_data[15:9] == 7'd0));

  assert_mask_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data[23:16] >> NS) == 8'd0));

  assert_empty_cell_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[23:16] == 8'd0) |-> (out_data[15:0] == 16'd0));

endmodule

bind scale_peak_packer spp_peak_checker #(.NS(NS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/scale_peak_packer_tb_top.sv
module scale_peak_packer_tb_top;

  localparam int DW = 8;
  localparam int NS = 4;
  localparam int NL = NS + 2;
  localparam int PW = NL * DW;
  localparam int MW = 16;
  localparam int MH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    cfg_width = 5'd2;
  logic [4:0]    cfg_height = 5'd2;
  logic [7:0]    cfg_octave = 8'd0;
  logic [DW-1:0] cfg_floor = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [PW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [31:0]   out_data;

  int n_checks = 0;
  int n_errors = 0;

  logic [PW-1:0] img [0:MH-1][0:MW-1];
  logic [31:0]   expw [0:63];
  int            n_exp;
  logic [15:0]   rs = 16'hACE1;

  always #2 clk = ~clk;

  scale_peak_packer #(.DW(DW), .NS(NS), .MAXW(MW), .MAXH(MH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_octave(cfg_octave), .cfg_floor(cfg_floor), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [15:0] nx(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] ex);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  function automatic int px(input int x, input int y, input int l);
    return int'(img[y][x][l*DW +: DW]);
  endfunction

  task automatic fill_const(input int v);
    for (int y = 0; y < MH; y++)
      for (int x = 0; x < MW; x++)
        for (int l = 0; l < NL; l++) img[y][x][l*DW +: DW] = DW'(v);
  endtask

  task automatic fill_rand(input logic [15:0] seed, input logic [7:0] rmask);
    rs = seed;
    for (int y = 0; y < MH; y++)
      for (int x = 0; x < MW; x++)
        for (int l = 0; l < NL; l++) begin
          rs = nx(rs);
          img[y][x][l*DW +: DW] = rs[7:0] & rmask;
        end
  endtask

  task automatic poke(input int x, input int y, input int l, input int v);
    img[y][x][l*DW +: DW] = DW'(v);
  endtask

  function automatic logic [NS-1:0] pix_mask(input int x, input int y, input int w, input int h, input int fl);
    logic [NS-1:0] m = '0;
    if (x < 1 || y < 1 || x > w - 2 || y > h - 2) return '0;
    for (int s = 0; s < NS; s++) begin
      int c = px(x, y, s + 1);
      bit ok = (c > fl);
      for (int dy = -1; dy <= 1; dy++)
        for (int dx = -1; dx <= 1; dx++)
          for (int dl = 0; dl < 3; dl++)
            if (!(dx == 0 && dy == 0 && dl == 1))
              if (px(x + dx, y + dy, s + dl) >= c) ok = 0;
      m[s] = ok;
    end
    return m;
  endfunction

  task automatic build_expect(input int w, input int h, input int fl, input logic [7:0] oct);
    n_exp = 0;
    for (int cy = 0; cy < h / 2; cy++)
      for (int cx = 0; cx < w / 2; cx++) begin
        logic [31:0] wd = {oct, 24'd0};
        bit found = 0;
        for (int k = 0; k < 4; k++) begin
          logic [NS-1:0] m = pix_mask(2*cx + (k % 2), 2*cy + (k / 2), w, h, fl);
          if (!found && m != '0) begin
            found = 1;
            wd[23:16] = 8'(m);
            wd[15:8]  = 8'(k / 2);
            wd[7:0]   = 8'(k % 2);
          end
        end
        expw[n_exp] = wd;
        n_exp++;
      end
  endtask

  task automatic run_frame(input int w, input int h, input int fl, input logic [7:0] oct,
                           input int bp, input string tag);
    int sent = 0;
    int got = 0;
    int guard = 0;
    bit stall_prev = 0;
    logic [31:0] stall_d = '0;
    build_expect(w, h, fl, oct);
    cfg_width  = 5'(w);
    cfg_height = 5'(h);
    cfg_floor  = DW'(fl);
    cfg_octave = oct;
    while ((sent < w * h || got < n_exp) && guard < 20000) begin
      @(negedge clk);
      rs = nx(rs);
      out_ready = (bp == 0) ? 1'b1 : (rs[3] | rs[9]) & ~rs[0];
      in_valid  = (sent < w * h) && ((bp == 0) || rs[5] || rs[11]);
      in_data   = (sent < w * h) ? img[sent / w][sent % w] : '0;
      #1;
      if (stall_prev) chk(out_valid && out_data == stall_d, "R9 stalled word changed", out_data, stall_d);
      stall_prev = out_valid && !out_ready;
      stall_d    = out_data;
      if (out_valid && out_ready) begin
        if (got < n_exp) chk(out_data == expw[got], tag, out_data, expw[got]);
        else chk(1'b0, "R2 extra word", out_data, 32'd0);
        got++;
      end
      if (in_valid && in_ready) sent++;
      guard++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    chk(got == n_exp && sent == w * h, "R2/R10 word count", 32'(got), 32'(n_exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk(in_ready, "R1 in_ready after reset", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: flat image, every comparison ties
    fill_const(5);
    run_frame(8, 6, 0, 8'h03, 0, "R4 ties suppress");

    // R3 and R10: small-range noise, new octave, back to back
    fill_rand(16'h1234, 8'h03);
    run_frame(8, 8, 0, 8'hA5, 0, "R3/R10 layout");

    // R9: full-range noise under back-pressure
    fill_rand(16'h7E51, 8'hFF);
    run_frame(16, 16, 0, 8'h11, 1, "R9 backpressure");

    // R7: same image, high floor
    run_frame(16, 16, 200, 8'h12, 1, "R7 floor");

    // R6: peaks on the frame border
    fill_const(10);
    poke(0, 2, 1, 200); poke(2, 0, 2, 200); poke(5, 3, 3, 200); poke(3, 5, 4, 200);
    poke(2, 2, 1, 200);
    run_frame(6, 6, 0, 8'h20, 0, "R6 border");

    // R5: outer lanes only as neighbours
    fill_const(10);
    poke(2, 2, 0, 200); poke(3, 3, 5, 200); poke(3, 2, 2, 50);
    poke(2, 3, 1, 100); poke(4, 3, 4, 100);
    run_frame(6, 6, 0, 8'h21, 0, "R5 outer lanes");

    // R8: two detections in one cell, priority order
    fill_const(10);
    poke(4, 4, 4, 100); poke(5, 5, 1, 100); poke(3, 2, 3, 100); poke(2, 3, 1, 100);
    run_frame(8, 8, 0, 8'h22, 1, "R8 cell priority");

    // R2: smallest frame
    fill_rand(16'h0F0F, 8'hFF);
    run_frame(2, 2, 0, 8'h30, 0, "R2 minimum frame");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule